// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Test-Forcing Block

This block holds the interrupt bookkeeping of a four-channel SPI controller: a sticky event register, its enable mask, a module-control register and a system-test register. Each channel reports transmit-empty and receive-full events as single-cycle pulses. These pulses latch into fixed status bits. Software clears status bits by writing ones to them. A single level-sensitive interrupt line is raised whenever any enabled status bit is set.

A diagnostic mode lets software force every implemented interrupt source to the active state, and it blocks clearing while the mode is in force. The mode is tracked by a four-state machine that holds the module-control test-mode bit and the system-test trigger bit:

- `TM_IDLE`: both bits clear.
- `TM_BIT_ONLY`: only the trigger bit is set.
- `TM_MODE_ONLY`: only test mode is on.
- `TM_FROZEN`: both are set, and clearing is blocked.

The transitions are driven by register writes:

- A module-control write with bit 3 set moves `TM_IDLE` to `TM_MODE_ONLY` and `TM_BIT_ONLY` to `TM_FROZEN`.
- A module-control write with bit 3 clear moves `TM_MODE_ONLY` to `TM_IDLE` and `TM_FROZEN` to `TM_BIT_ONLY`.
- A system-test write with bit 11 set moves `TM_IDLE` to `TM_BIT_ONLY` and `TM_MODE_ONLY` to `TM_FROZEN`.
- A system-test write with bit 11 clear moves `TM_BIT_ONLY` to `TM_IDLE` and `TM_FROZEN` to `TM_MODE_ONLY`.
- A soft reset returns any state to `TM_IDLE`.

Software reaches the block through a simple word-wide register port. Reads return data one cycle after the request.

Top module: `spi_irq_ctrl`

## Requirements
- R1: A pulse on `tx_empty_evt[n]` sets status bit 4n, and a pulse on `rx_full_evt[n]` sets status bit 4n+2, at the next clock edge. Status is read at offset 0x18.
- R2: The enable register at offset 0x1C stores only the bits of mask 0x1777F and reads back masked.
- R3: `irq` is high exactly when status AND enable is nonzero. It follows a register change in the same cycle that the change becomes visible.
- R4: A write to offset 0x18 clears each status bit written as one. An event arriving in the same cycle wins, so its bit stays set.
- R5: A write to offset 0x18 is ignored while module-control bit 3 and system-test bit 11 are both set.
- R6: Two writes set every status bit in 0x1777F. The first is a system-test write (offset 0x24) with bit 11 set while module-control bit 3 is set. The second is a module-control write (offset 0x28) with bit 3 set while system-test bit 11 is set.
- R7: After reset, module control reads 0x4 and the other writable registers read 0. System test keeps 12 bits and module control keeps 4 bits.
- R8: System configuration (offset 0x10) stores the write data AND 0x31D. A write with bit 1 set returns status, enable, system test and module control to their reset values.
- R9: Offset 0x00 reads 0x91, and offset 0x14 reads 1.
- R10: Accesses to unmapped offsets, and accesses whose size code is not 2 (32-bit), read 0 and change nothing.
- R11: Read data appears on `bus_rdata` the cycle after a read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code; only 2 (32-bit) is accepted |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_empty_evt | input | 4 | Per-channel transmit-empty event pulses |
| rx_full_evt | input | 4 | Per-channel receive-full event pulses |
| irq | output | 1 | Interrupt request, OR of the enabled status bits |

## Verification
Every register, including the test-mode state, updates on the clock edge that ends a write or event cycle. `irq` is derived from those registers without a further stage, so both register effects and `irq` are due one edge after the stimulus. Read data is also due one edge after the read request. The bench drives each access or event on a falling edge, lets exactly one rising edge pass, and samples `irq` or `bus_rdata` on the following falling edge. The effects of writes and events are observed through later reads, each again sampled one edge after its request.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    typedef enum logic [1:0] {
        TM_IDLE      = 2'b00,
        TM_BIT_ONLY  = 2'b01,
        TM_MODE_ONLY = 2'b10,
        TM_FROZEN    = 2'b11
    } tm_state_e;

    localparam int NREG = 7;
    localparam int IX_REV  = 0;
    localparam int IX_SCFG = 1;
    localparam int IX_SSTA = 2;
    localparam int IX_STAT = 3;
    localparam int IX_EN   = 4;
    localparam int IX_SYST = 5;
    localparam int IX_MOD  = 6;

    localparam logic [7:0] REG_OFFS [NREG] = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h24, 8'h28};

    localparam logic [1:0] SIZE_WORD  = 2'b10;
    localparam logic [7:0] REV_VALUE  = 8'h91;
    localparam logic [9:0] SCFG_MASK  = 10'h31D;
    localparam int         MODE_BIT   = 3;
    localparam int         TRIG_BIT   = 11;
    localparam int         SRST_BIT   = 1;

endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NREG-1:0]   rd_sel,
    output logic [NREG-1:0]   wr_sel
);

    logic acc_ok;
    logic [NREG-1:0] hit;

    assign acc_ok = bus_req && (bus_size == SIZE_WORD);

    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = acc_ok && (bus_addr == ADDR_W'(REG_OFFS[i]));
    end

    assign rd_sel = bus_we ? '0 : hit;
    assign wr_sel = bus_we ? hit : '0;

endmodule

// File: rtl/spi_irq_testfsm.sv
module spi_irq_testfsm
    import spi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic wr_mod,
    input  logic wr_syst,
    input  logic mode_in,
    input  logic trig_in,
    output logic mode_on,
    output logic trig_on,
    output logic freeze,
    output logic force_all
);

    tm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TM_IDLE: begin
                if (wr_mod && mode_in)        state_d = TM_MODE_ONLY;
                else if (wr_syst && trig_in)  state_d = TM_BIT_ONLY;
            end
            TM_BIT_ONLY: begin
                if (wr_mod && mode_in)        state_d = TM_FROZEN;
                else if (wr_syst && !trig_in) state_d = TM_IDLE;
            end
            TM_MODE_ONLY: begin
                if (wr_syst && trig_in)       state_d = TM_FROZEN;
                else if (wr_mod && !mode_in)  state_d = TM_IDLE;
            end
            TM_FROZEN: begin
                if (wr_mod && !mode_in)       state_d = TM_BIT_ONLY;
                else if (wr_syst && !trig_in) state_d = TM_MODE_ONLY;
            end
            default: state_d = TM_IDLE;
        endcase
        if (soft_rst) state_d = TM_IDLE;
    end

    always_comb begin
        mode_on = 1'b0;
        trig_on = 1'b0;
        unique case (state_q)
            TM_IDLE:      ;
            TM_BIT_ONLY:  trig_on = 1'b1;
            TM_MODE_ONLY: mode_on = 1'b1;
            TM_FROZEN: begin
                mode_on = 1'b1;
                trig_on = 1'b1;
            end
            default: ;
        endcase
        freeze    = mode_on && trig_on;
        force_all = (wr_syst && trig_in && mode_on) || (wr_mod && mode_in && trig_on);
    end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
    parameter int NUM_CH = 4,
    parameter int STAT_W = 17,
    parameter logic [STAT_W-1:0] MASK = 17'h1777F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [NUM_CH-1:0] tx_evt,
    input  logic [NUM_CH-1:0] rx_evt,
    input  logic              clr_en,
    input  logic [STAT_W-1:0] clr_bits,
    input  logic              force_all,
    output logic [STAT_W-1:0] status_q
);

    logic [STAT_W-1:0] set_bits;
    logic [STAT_W-1:0] status_d;

    always_comb begin
        set_bits = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            set_bits[4*n]     = tx_evt[n];
            set_bits[4*n + 2] = rx_evt[n];
        end
    end

    always_comb begin
        status_d = status_q;
        if (clr_en) status_d = status_d & ~clr_bits;
        status_d = status_d | set_bits;
        if (force_all) status_d = status_d | MASK;
        status_d = status_d & MASK;
        if (soft_rst) status_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [31:0] IRQ_MASK = 32'h0001_777F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] tx_empty_evt,
    input  logic [NUM_CH-1:0] rx_full_evt,
    output logic              irq
);

    localparam int STAT_W = $clog2(IRQ_MASK + 1);
    localparam int SCFG_W = $bits(SCFG_MASK);
    localparam logic [STAT_W-1:0] STAT_MASK = IRQ_MASK[STAT_W-1:0];

    logic [NREG-1:0]   rd_sel, wr_sel;
    logic              soft_rst;
    logic              mode_on, trig_on, freeze, force_all;
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] enable_q;
    logic [SCFG_W-1:0] scfg_q;
    logic [TRIG_BIT-1:0] syst_lo_q;
    logic [MODE_BIT-1:0] mod_lo_q;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata;

    spi_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_size (bus_size),
        .bus_addr (bus_addr),
        .rd_sel   (rd_sel),
        .wr_sel   (wr_sel)
    );

    assign soft_rst = wr_sel[IX_SCFG] && bus_wdata[SRST_BIT];

    spi_irq_testfsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .wr_mod    (wr_sel[IX_MOD]),
        .wr_syst   (wr_sel[IX_SYST]),
        .mode_in   (bus_wdata[MODE_BIT]),
        .trig_in   (bus_wdata[TRIG_BIT]),
        .mode_on   (mode_on),
        .trig_on   (trig_on),
        .freeze    (freeze),
        .force_all (force_all)
    );

    spi_irq_status #(.NUM_CH(NUM_CH), .STAT_W(STAT_W), .MASK(STAT_MASK)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .tx_evt    (tx_empty_evt),
        .rx_evt    (rx_full_evt),
        .clr_en    (wr_sel[IX_STAT] && !freeze),
        .clr_bits  (bus_wdata[STAT_W-1:0]),
        .force_all (force_all),
        .status_q  (status_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q  <= '0;
            scfg_q    <= '0;
            syst_lo_q <= '0;
            mod_lo_q  <= MODE_BIT'(4);
        end else begin
            if (soft_rst) begin
                enable_q  <= '0;
                syst_lo_q <= '0;
                mod_lo_q  <= MODE_BIT'(4);
            end else begin
                if (wr_sel[IX_EN])   enable_q  <= bus_wdata[STAT_W-1:0] & STAT_MASK;
                if (wr_sel[IX_SYST]) syst_lo_q <= bus_wdata[TRIG_BIT-1:0];
                if (wr_sel[IX_MOD])  mod_lo_q  <= bus_wdata[MODE_BIT-1:0];
            end
            if (wr_sel[IX_SCFG]) scfg_q <= bus_wdata[SCFG_W-1:0] & SCFG_MASK;
        end
    end

    always_comb begin
        rd_val = '0;
        if (rd_sel[IX_REV])  rd_val = DATA_W'(REV_VALUE);
        if (rd_sel[IX_SCFG]) rd_val = DATA_W'(scfg_q);
        if (rd_sel[IX_SSTA]) rd_val = DATA_W'(1);
        if (rd_sel[IX_STAT]) rd_val = DATA_W'(status_q);
        if (rd_sel[IX_EN])   rd_val = DATA_W'(enable_q);
        if (rd_sel[IX_SYST]) rd_val = DATA_W'({trig_on, syst_lo_q});
        if (rd_sel[IX_MOD])  rd_val = DATA_W'({mode_on, mod_lo_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rdata_q <= '0;
        else if (bus_req && !bus_we) rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;
    assign irq       = |(status_q & enable_q);

endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int STAT_W = 17,
    parameter logic [31:0] IRQ_MASK = 32'h0001_777F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] tx_empty_evt,
    input logic [NUM_CH-1:0] rx_full_evt,
    input logic              irq,
    input logic [STAT_W-1:0] status_q,
    input logic [STAT_W-1:0] enable_q,
    input logic              mode_on,
    input logic              trig_on
);

    logic wacc, srst_wr, clr_wr, en_wr, syst_wr;

    assign wacc    = bus_req && bus_we && (bus_size == 2'b10);
    assign srst_wr = wacc && (bus_addr == ADDR_W'(8'h10)) && bus_wdata[1];
    assign clr_wr  = wacc && (bus_addr == ADDR_W'(8'h18));
    assign en_wr   = wacc && (bus_addr == ADDR_W'(8'h1C));
    assign syst_wr = wacc && (bus_addr == ADDR_W'(8'h24));

    // R1
    p_tx_evt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty_evt[0] && !srst_wr) |=> status_q[0]);
    p_rx_evt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full_evt[0] && !srst_wr) |=> status_q[2]);
    // R3
    p_irq_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && ((bus_wdata & IRQ_MASK) == '0)) |=> !irq);
    // R5
    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && mode_on && trig_on) |=> ((status_q & $past(status_q)) == $past(status_q)));
    // R6
    p_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (syst_wr && bus_wdata[11] && mode_on) |=> (status_q == IRQ_MASK[STAT_W-1:0]));
    // R8
    p_soft_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> (status_q == '0 && enable_q == '0 && !irq && !mode_on && !trig_on));
    // R10
    p_badsize_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_size != 2'b10) |=> (bus_rdata == '0));

endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W), .IRQ_MASK(IRQ_MASK)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_size     (bus_size),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .tx_empty_evt (tx_empty_evt),
    .rx_full_evt  (rx_full_evt),
    .irq          (irq),
    .status_q     (status_q),
    .enable_q     (enable_q),
    .mode_on      (mode_on),
    .trig_on      (trig_on)
);

// File: tb/test_spi_irq_ctrl.sv
module test_spi_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'b10;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tx_empty_evt = '0;
    logic [3:0]  rx_full_evt = '0;
    logic        irq;

    int n_tot = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    spi_irq_ctrl i_spi_irq_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_size     (bus_size),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .tx_empty_evt (tx_empty_evt),
        .rx_full_evt  (rx_full_evt),
        .irq          (irq)
    );

    // {we, addr, wdata, expected read data}
    localparam int NV = 17;
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 8'h00, 32'h0,        32'h0000_0091},
        {1'b0, 8'h14, 32'h0,        32'h0000_0001},
        {1'b0, 8'h28, 32'h0,        32'h0000_0004},
        {1'b1, 8'h1C, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h1C, 32'h0,        32'h0001_777F},
        {1'b1, 8'h24, 32'h0000_FFFF, 32'h0},
        {1'b0, 8'h24, 32'h0,        32'h0000_0FFF},
        {1'b0, 8'h18, 32'h0,        32'h0000_0000},
        {1'b1, 8'h28, 32'h0000_00FF, 32'h0},
        {1'b0, 8'h28, 32'h0,        32'h0000_000F},
        {1'b0, 8'h18, 32'h0,        32'h0001_777F},
        {1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h18, 32'h0,        32'h0001_777F},
        {1'b1, 8'h28, 32'h0,        32'h0},
        {1'b1, 8'h18, 32'h0000_0001, 32'h0},
        {1'b0, 8'h18, 32'h0,        32'h0001_777E},
        {1'b0, 8'h50, 32'h0,        32'h0000_0000}
    };
    localparam string VTAG [NV] = '{"R9", "R9", "R7", "R2", "R2", "R7", "R7", "R6",
                                   "R6", "R7", "R6", "R5", "R5", "R4", "R4", "R4", "R10"};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'b10);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_size = 2'b10;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v, input logic [1:0] sz = 2'b10);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
        @(negedge clk);
        v = bus_rdata;
        bus_req = 1'b0; bus_size = 2'b10;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tot++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 irq at reset", {31'b0, irq}, 32'h0);
        chk("R11 rdata at reset", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][71:64], v);
                chk(VTAG[i], v, VEC[i][31:0]);
            end
        end

        // R11: read data holds across idle cycles and writes
        @(negedge clk);
        wr(8'h20, 32'h1);
        chk("R11 hold", bus_rdata, 32'h0);

        // R3: status 0x1777E, enable 0x1777F
        chk("R3 irq on", {31'b0, irq}, 32'h1);
        wr(8'h1C, 32'h0);
        chk("R3 irq off", {31'b0, irq}, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        rdchk("R4 clear all", 8'h18, 32'h0);

        // R1: channel event pulses
        tx_empty_evt = 4'b1010; rx_full_evt = 4'b0101;
        @(negedge clk);
        tx_empty_evt = '0; rx_full_evt = '0;
        rdchk("R1 event map", 8'h18, 32'h0000_1414);

        wr(8'h1C, 32'h4);
        chk("R3 irq from bit2", {31'b0, irq}, 32'h1);
        wr(8'h18, 32'h4);
        chk("R3 irq after clear", {31'b0, irq}, 32'h0);

        // R4: event beats a simultaneous clear
        tx_empty_evt = 4'b0001;
        wr(8'h18, 32'hFFFF_FFFF);
        tx_empty_evt = '0;
        rdchk("R4 event priority", 8'h18, 32'h1);

        // R10: bad size and unmapped
        wr(8'h1C, 32'hFFFF_FFFF, 2'b01);
        rdchk("R10 bad-size write", 8'h1C, 32'h4);
        rd(8'h00, v, 2'b00);
        chk("R10 bad-size read", v, 32'h0);
        rdchk("R10 unmapped read", 8'h20, 32'h0);

        // R6: trigger path through the system-test register
        wr(8'h24, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h28, 32'h8);
        rdchk("R6 mode alone no force", 8'h18, 32'h0);
        wr(8'h24, 32'h800);
        rdchk("R6 trigger force", 8'h18, 32'h0001_777F);
        rdchk("R7 syst width", 8'h24, 32'h800);

        // R8: system configuration and soft reset
        wr(8'h10, 32'hFFFF_FFFD);
        rdchk("R8 scfg mask", 8'h10, 32'h31D);
        wr(8'h1C, 32'h1);
        wr(8'h10, 32'h2);
        chk("R8 irq after soft reset", {31'b0, irq}, 32'h0);
        rdchk("R8 status", 8'h18, 32'h0);
        rdchk("R8 enable", 8'h1C, 32'h0);
        rdchk("R8 syst", 8'h24, 32'h0);
        rdchk("R8 modctrl", 8'h28, 32'h4);
        rdchk("R8 scfg", 8'h10, 32'h0);

        finish_run();
    end

endmodule